// File: doc/BRIEF.md
# DRAM Traffic Profiling Counter Unit

This unit sits next to a DRAM controller and keeps six running statistics on its traffic: elapsed clock cycles, cycles in which the controller reports itself busy, accepted read commands, accepted write commands, and the byte totals moved by read beats and by write beats. The controller drives one strobe per event each cycle. Read and write beats also carry a byte count, which is added to the byte counters. A simple register port with one-cycle read latency gives software a single control word and six read-only counter words.

Software starts a measurement with two writes to the control word. The first write sets only the clear bit, which zeroes every counter and the overflow flag. The second write sets the enable bit, and optionally the source-select bit. Counting then runs until software writes the freeze bit, which holds every counter so the values can be read at leisure. No interrupt is raised. The cycle counter grows fastest, so software must poll often enough to catch its wrap, and a sticky overflow flag records that a wrap happened. When the source-select bit is set, only traffic that the controller marks with a master-match strobe is counted. The cycle counter still advances on every cycle.

Top module: `mc_prof_counters`

## Requirements
- R1: After a synchronous reset, the control word reads 0x0 and all six counter words read zero.
- R2: The control word sits at offset 0x410 and has these fields: bit 0 enable, bit 1 clear, bit 2 freeze, bit 3 overflow flag (read-only), bit 4 source select. Each write replaces the enable, freeze and select bits. Writing 0x0 stops all counting, so later event strobes leave the counters unchanged.
- R3: A write with bit 1 set zeroes all six counters and the overflow flag at the same clock edge that takes the write. Bit 1 always reads back as 0.
- R4: While enable is 1 and freeze is 0, the cycle counter rises by one on every clock edge. Each counter is CNT_W bits wide (default 32) and wraps modulo 2^CNT_W.
- R5: While counting, the busy, read-access and write-access counters each rise by one on every edge at which their strobe is high.
- R6: While counting, the read-byte and write-byte counters add the beat's byte-count input on every edge at which the matching beat strobe is high.
- R7: While freeze is 1, no counter changes, and repeated reads return the same held values.
- R8: The overflow flag is set when the cycle counter wraps from all ones to zero. It stays set through later writes that do not set bit 1.
- R9: When select is 0, traffic from every master is counted. When select is 1, the busy, access and byte counters advance only on cycles where the master-match input is high, while the cycle counter is unaffected.
- R10: A read returns its data on reg_rdata in the cycle after reg_rd, holding the register value from before the edge that took the read. reg_rdata is zero in cycles that follow no read. Unmapped or misaligned offsets read as zero.
- R11: The six counters sit at word offsets 0x418, 0x41C, 0x420, 0x424, 0x428 and 0x42C, holding in that order the cycle, busy, read-access, write-access, read-byte and write-byte counts. Counters narrower than the data bus are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_busy | input | 1 | Controller busy this cycle |
| ev_rd_acc | input | 1 | Read command accepted this cycle |
| ev_wr_acc | input | 1 | Write command accepted this cycle |
| ev_rd_beat | input | 1 | Read data beat transferred this cycle |
| ev_rd_bytes | input | INC_W | Bytes in the read beat |
| ev_wr_beat | input | 1 | Write data beat transferred this cycle |
| ev_wr_bytes | input | INC_W | Bytes in the write beat |
| ev_match | input | 1 | This cycle's traffic belongs to the selected master |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that reg_wr and reg_rd are never high together, that every strobe is a clean 0 or 1 sampled at the rising edge, and that the byte-count inputs matter only when their beat strobe is high. The bench changes inputs only on falling edges and issues exactly one register operation at a time. To make the cycle counter's wrap reachable within a short run, the bench narrows CNT_W to 10 bits. Each scenario's expected counts come from the strobe patterns the bench drives itself, and the bench reads the counters only while they are frozen or at a cycle it has counted exactly.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int NUM_CNT      = 6;
  localparam int CTRL_OFS     = 'h410;
  localparam int CNT_BASE_OFS = 'h418;
  localparam int CNT_STRIDE   = 4;

  localparam int B_EN  = 0;
  localparam int B_CLR = 1;
  localparam int B_FRZ = 2;
  localparam int B_OVF = 3;
  localparam int B_SEL = 4;
  localparam int CTRL_FIELD_W = B_SEL + 1;

  typedef enum logic [2:0] {
    IDX_CYC   = 3'd0,
    IDX_BUSY  = 3'd1,
    IDX_RACC  = 3'd2,
    IDX_WACC  = 3'd3,
    IDX_RBYTE = 3'd4,
    IDX_WBYTE = 3'd5
  } cnt_idx_e;
endpackage

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_ctrl,
  input  logic [CTRL_FIELD_W-1:0] wfield,
  input  logic                    total_wrap,
  output logic                    en,
  output logic                    frz,
  output logic                    sel,
  output logic                    ovf,
  output logic                    clr_pulse,
  output logic [DATA_W-1:0]       ctrl_word
);

  always_comb clr_pulse = wr_ctrl & wfield[B_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      frz <= 1'b0;
      sel <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en  <= wfield[B_EN];
        frz <= wfield[B_FRZ];
        sel <= wfield[B_SEL];
      end
      if (clr_pulse)       ovf <= 1'b0;
      else if (total_wrap) ovf <= 1'b1;
    end
  end

  always_comb begin
    ctrl_word        = '0;
    ctrl_word[B_EN]  = en;
    ctrl_word[B_FRZ] = frz;
    ctrl_word[B_OVF] = ovf;
    ctrl_word[B_SEL] = sel;
  end

  // R2: a write replaces the enable bit
  p_en_follows_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> en == $past(wfield[B_EN]));
  // R8: overflow flag is sticky until a clear
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_pulse) |=> ovf);
  // R3: a clear drops the overflow flag
  p_ovf_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> !ovf);
endmodule

// File: rtl/mcp_evsel.sv
module mcp_evsel
  import mcp_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic                            sel,
  input  logic                            match,
  input  logic                            busy,
  input  logic                            rd_acc,
  input  logic                            wr_acc,
  input  logic                            rd_beat,
  input  logic [INC_W-1:0]                rd_bytes,
  input  logic                            wr_beat,
  input  logic [INC_W-1:0]                wr_bytes,
  output logic [NUM_CNT-1:0][INC_W-1:0]   incs
);
  logic qual;

  always_comb begin
    qual = !sel || match;
    incs = '0;
    incs[IDX_CYC]   = INC_W'(1);
    incs[IDX_BUSY]  = INC_W'(qual && busy);
    incs[IDX_RACC]  = INC_W'(qual && rd_acc);
    incs[IDX_WACC]  = INC_W'(qual && wr_acc);
    incs[IDX_RBYTE] = (qual && rd_beat) ? rd_bytes : '0;
    incs[IDX_WBYTE] = (qual && wr_beat) ? wr_bytes : '0;
  end
endmodule

// File: rtl/mcp_counter.sv
module mcp_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W:0] sum;

  always_comb begin
    sum  = {1'b0, count} + (CNT_W+1)'(inc);
    wrap = cnt_en && !clr && sum[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (cnt_en) count <= sum[CNT_W-1:0];
  end

  // R3: clear zeroes the counter at the next edge
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
  // R7: with counting stopped the value is held
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !cnt_en) |=> $stable(count));
  // R6: counting adds the increment modulo 2^CNT_W
  p_add_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt_en) |=> count == CNT_W'($past(count) + CNT_W'($past(inc))));
endmodule

// File: rtl/mcp_rdport.sv
module mcp_rdport
  import mcp_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             ctrl_word,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] counts,
  output logic [DATA_W-1:0]             rdata
);
  logic [ADDR_W-1:0] rel;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    rel      = addr - ADDR_W'(CNT_BASE_OFS);
    sel_data = '0;
    if (addr == ADDR_W'(CTRL_OFS)) sel_data = ctrl_word;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rel == ADDR_W'(CNT_STRIDE * i)) sel_data = DATA_W'(counts[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel_data;
    else         rdata <= '0;
  end

  // R10: no read, no data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
  // R10: misaligned offsets read as zero
  p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[1:0] != 2'b00) |=> rdata == '0);
endmodule

// File: rtl/mc_prof_counters.sv
module mc_prof_counters
  import mcp_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int INC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_busy,
  input  logic              ev_rd_acc,
  input  logic              ev_wr_acc,
  input  logic              ev_rd_beat,
  input  logic [INC_W-1:0]  ev_rd_bytes,
  input  logic              ev_wr_beat,
  input  logic [INC_W-1:0]  ev_wr_bytes,
  input  logic              ev_match,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic en, frz, sel, ovf, clr_pulse, wr_ctrl, cnt_active;
  logic [DATA_W-1:0]             ctrl_word;
  logic [NUM_CNT-1:0][INC_W-1:0] incs;
  logic [NUM_CNT-1:0][CNT_W-1:0] counts;
  logic [NUM_CNT-1:0]            wraps;

  always_comb begin
    wr_ctrl    = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
    cnt_active = en && !frz;
  end

  mcp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl),
    .wfield(reg_wdata[CTRL_FIELD_W-1:0]), .total_wrap(wraps[IDX_CYC]),
    .en(en), .frz(frz), .sel(sel), .ovf(ovf), .clr_pulse(clr_pulse),
    .ctrl_word(ctrl_word)
  );

  mcp_evsel #(.INC_W(INC_W)) u_evsel (
    .sel(sel), .match(ev_match), .busy(ev_busy), .rd_acc(ev_rd_acc),
    .wr_acc(ev_wr_acc), .rd_beat(ev_rd_beat), .rd_bytes(ev_rd_bytes),
    .wr_beat(ev_wr_beat), .wr_bytes(ev_wr_bytes), .incs(incs)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    mcp_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr_pulse), .cnt_en(cnt_active),
      .inc(incs[g]), .count(counts[g]), .wrap(wraps[g])
    );
  end

  mcp_rdport #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdport (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr),
    .ctrl_word(ctrl_word), .counts(counts), .rdata(reg_rdata)
  );

  // R4: cycle counter steps by one every active edge
  p_total_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_active && !clr_pulse) |=> counts[IDX_CYC] == CNT_W'($past(counts[IDX_CYC]) + 1'b1));
  // R8: a wrap of the cycle counter leaves the overflow flag set
  p_wrap_sets_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_active && !clr_pulse && counts[IDX_CYC] == '1) |=> ovf);
  // R9: with select set and no match, the busy count holds
  p_select_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (sel && !ev_match && !clr_pulse) |=> $stable(counts[IDX_BUSY]));
endmodule

// File: tb/mc_prof_counters_test.sv
`timescale 1ns/1ps
module mc_prof_counters_test;
  localparam int CW = 10;
  localparam int IW = 8;
  localparam logic [11:0] A_CTRL = 12'h410;
  localparam logic [11:0] A_CYC = 12'h418, A_BUSY = 12'h41C, A_RACC = 12'h420;
  localparam logic [11:0] A_WACC = 12'h424, A_RBYTE = 12'h428, A_WBYTE = 12'h42C;

  logic clk = 0, rst = 1;
  logic ev_busy = 0, ev_rd_acc = 0, ev_wr_acc = 0, ev_rd_beat = 0, ev_wr_beat = 0, ev_match = 0;
  logic [IW-1:0] ev_rd_bytes = 0, ev_wr_bytes = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mc_prof_counters #(.CNT_W(CW), .INC_W(IW)) uut (
    .clk(clk), .rst(rst), .ev_busy(ev_busy), .ev_rd_acc(ev_rd_acc),
    .ev_wr_acc(ev_wr_acc), .ev_rd_beat(ev_rd_beat), .ev_rd_bytes(ev_rd_bytes),
    .ev_wr_beat(ev_wr_beat), .ev_wr_bytes(ev_wr_bytes), .ev_match(ev_match),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_events();
    ev_busy = 0; ev_rd_acc = 0; ev_wr_acc = 0; ev_rd_beat = 0;
    ev_wr_beat = 0; ev_match = 0; ev_rd_bytes = 0; ev_wr_bytes = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    cycle();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic start(logic [31:0] en_word);
    reg_write(A_CTRL, 32'h2);
    reg_write(A_CTRL, en_word);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(A_CTRL, v);  check("R1 ctrl after reset", v, 32'h0);
    reg_read(A_CYC, v);   check("R1 cycles after reset", v, 0);
    reg_read(A_BUSY, v);  check("R1 busy after reset", v, 0);
    reg_read(A_RACC, v);  check("R1 rd acc after reset", v, 0);
    reg_read(A_WACC, v);  check("R1 wr acc after reset", v, 0);
    reg_read(A_RBYTE, v); check("R1 rd bytes after reset", v, 0);
    reg_read(A_WBYTE, v); check("R1 wr bytes after reset", v, 0);
  endtask

  task automatic t_counts();
    logic [31:0] v;
    start(32'h1);
    for (int i = 0; i < 20; i++) begin
      ev_busy = 1; ev_rd_acc = (i % 2 == 0); ev_wr_acc = (i % 3 == 0);
      ev_rd_beat = (i % 4 == 0); ev_rd_bytes = IW'(i + 1);
      ev_wr_beat = (i % 2 == 1); ev_wr_bytes = 8'd5;
      cycle();
    end
    idle_events();
    reg_write(A_CTRL, 32'h4);
    reg_read(A_CYC, v);   check("R4 R11 cycle count", v, 21);
    reg_read(A_BUSY, v);  check("R5 R11 busy count", v, 20);
    reg_read(A_RACC, v);  check("R5 R11 read accesses", v, 10);
    reg_read(A_WACC, v);  check("R5 R11 write accesses", v, 7);
    reg_read(A_RBYTE, v); check("R6 R11 read bytes", v, 45);
    reg_read(A_WBYTE, v); check("R6 R11 write bytes", v, 50);
    ev_busy = 1; ev_rd_acc = 1;
    repeat (4) cycle();
    idle_events();
    reg_read(A_CYC, v);   check("R7 frozen cycles held", v, 21);
    reg_read(A_BUSY, v);  check("R7 frozen busy held", v, 20);
    reg_read(A_CTRL, v);  check("R2 ctrl shows freeze only", v, 32'h4);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    reg_write(A_CTRL, 32'h2);
    reg_read(A_CYC, v);   check("R3 cleared cycles", v, 0);
    reg_read(A_RBYTE, v); check("R3 cleared rd bytes", v, 0);
    reg_read(A_CTRL, v);  check("R3 clear bit reads 0", v, 0);
  endtask

  task automatic t_live_read();
    logic [31:0] v;
    start(32'h1);
    repeat (7) cycle();
    reg_read(A_CYC, v);   check("R10 live read sees previous edge", v, 7);
    reg_read(12'h41A, v); check("R10 misaligned reads 0", v, 0);
    reg_read(12'h430, v); check("R10 past last counter reads 0", v, 0);
    reg_read(12'h000, v); check("R10 low offset reads 0", v, 0);
    cycle();
    check("R10 rdata zero without read", reg_rdata, 0);
    reg_write(A_CTRL, 32'h4);
  endtask

  task automatic t_select();
    logic [31:0] v;
    start(32'h11);
    reg_read(A_CTRL, v);  check("R9 select bit reads back", v, 32'h11);
    for (int i = 0; i < 16; i++) begin
      ev_busy = 1; ev_rd_acc = 1; ev_rd_beat = 1; ev_rd_bytes = 8'd3;
      ev_match = (i % 2 == 1);
      cycle();
    end
    idle_events();
    reg_write(A_CTRL, 32'h4);
    reg_read(A_CYC, v);   check("R9 cycles not gated", v, 18);
    reg_read(A_BUSY, v);  check("R9 busy gated by match", v, 8);
    reg_read(A_RACC, v);  check("R9 rd acc gated by match", v, 8);
    reg_read(A_RBYTE, v); check("R9 rd bytes gated by match", v, 24);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    start(32'h1);
    repeat (5) cycle();
    reg_write(A_CTRL, 32'h0);
    ev_busy = 1; ev_wr_beat = 1; ev_wr_bytes = 8'd9;
    repeat (10) cycle();
    idle_events();
    reg_read(A_CYC, v);   check("R2 disabled cycles stop", v, 6);
    reg_read(A_BUSY, v);  check("R2 disabled busy ignored", v, 0);
    reg_read(A_WBYTE, v); check("R2 disabled wr bytes ignored", v, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    start(32'h1);
    repeat (1030) cycle();
    reg_write(A_CTRL, 32'h4);
    reg_read(A_CYC, v);   check("R4 cycle count wrapped", v, 7);
    reg_read(A_CTRL, v);  check("R8 overflow flag set", v, 32'hC);
    reg_write(A_CTRL, 32'h0);
    reg_read(A_CTRL, v);  check("R8 overflow flag sticky", v, 32'h8);
    reg_write(A_CTRL, 32'h2);
    reg_read(A_CTRL, v);  check("R3 clear drops overflow", v, 0);
    reg_read(A_CYC, v);   check("R3 clear zeroes cycles", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_counts();
    t_clear();
    t_live_read();
    t_select();
    t_disable();
    t_wrap();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule